// File: doc/BRIEF.md
# Scanout Position Reporter

This block turns a raw reading of a display timing counter into a signed scanout position. The position is measured from the end of vertical blank. While the beam is inside vertical blank the position is negative and rises toward zero. Once active video starts it is positive.

Two counter kinds are accepted, and a mode input selects between them:

- **Line mode.** The raw value is a hardware scanline. It is corrected by a small signed offset, chosen per output type, and wrapped modulo the frame height.
- **Pixel mode.** The raw value is a pixel count taken from the start of the frame. It is clamped to the frame size and moved forward so that line boundaries fall at horizontal sync. It is then split into a line part and a pixel part.

The same pipeline also maps a logical scanline back to the value the hardware counter would show. This lets software program line-based compare points.

The computation is registered over three stages. Each accepted input yields one result strobe exactly three clock edges later. New inputs may be presented on every cycle.

Top module: `scanpos_reporter`

## Requirements
- R1: In line mode the corrected line is (raw + vt + k) mod vt, where vt is the frame height, raw is the low line-width bits of the raw input, and k is chosen by the 2-bit offset select: 00 gives k=-1, 01 gives k=+1, 10 gives k=+2, and 11 is treated as +1.
- R2: The hardware-line output equals (logical_line + vt - k) mod vt, with the same k as in R1, in both modes.
- R3: When interlace is high, the blank start is halved rounding up, while the blank end and the frame height are halved rounding down, before any other use.
- R4: In pixel mode a raw pixel count above vt*htotal-1 is replaced by vt*htotal-1.
- R5: In pixel mode the clamped count is increased by (htotal - hsync_start) and wrapped modulo vt*htotal.
- R6: The relative position p is taken in lines (line mode) or in pixels, with the thresholds multiplied by htotal (pixel mode). If p >= blank start the result is p - blank end; otherwise it is p + vt - blank end.
- R7: In line mode vpos equals the relative position and hpos is 0.
- R8: In pixel mode vpos is the relative position divided by htotal, truncated toward zero, and hpos is the remainder, which carries the sign of the relative position.
- R9: in_vblank is high exactly when vpos is negative. A pixel-mode position that is less than one line before blank end therefore reports in_vblank low.
- R10: out_valid rises exactly three clock edges after each cycle with in_valid high, and is low otherwise. Back-to-back inputs produce back-to-back results.
- R11: After reset, out_valid, vpos, hpos, in_vblank and hw_line are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe for all inputs |
| pix_mode | input | 1 | 1: raw is a pixel count, 0: raw is a scanline |
| interlace | input | 1 | Timing values describe an interlaced frame |
| ofs_sel | input | 2 | Scanline offset select (see R1) |
| raw_count | input | 2*LINE_W | Raw counter reading |
| logical_line | input | LINE_W | Logical line for the inverse mapping |
| htotal | input | LINE_W | Pixels per line |
| hsync_start | input | LINE_W | Pixel where horizontal sync starts |
| vtotal | input | LINE_W | Lines per frame |
| vblank_start | input | LINE_W | First blank line |
| vblank_end | input | LINE_W | Line where blank ends |
| out_valid | output | 1 | Result strobe |
| vpos | output | LINE_W+2 | Signed vertical position |
| hpos | output | LINE_W+2 | Signed horizontal position |
| in_vblank | output | 1 | Vertical position is negative |
| hw_line | output | LINE_W | Inverse-mapped hardware line |

## Verification
The bench targets the following corner cases:

- **Line wrap.** Raw line zero with the -1 offset must land on the last line and read as inside blank. A design that wraps wrongly reports a large positive line instead.
- **Blank start threshold.** The line just before blank start and the line at blank start must fall on opposite sides of zero. An off-by-one comparison moves that edge.
- **Truncating division.** A pixel count shortly before blank end gives a result of vpos 0 with a negative hpos and in_vblank low. A flooring divider would report vpos -1 instead.
- **Clamp and shift wrap.** Oversized raw counts and counts near the frame end must both wrap back to line zero.
- **Interlace rounding.** Interlaced values are chosen so that rounding the blank start or the blank end in the wrong direction changes the reported line.

// File: rtl/scanpos_pkg.sv
package scanpos_pkg;

    typedef enum logic [1:0] {
        OFS_MINUS1 = 2'b00,
        OFS_PLUS1  = 2'b01,
        OFS_PLUS2  = 2'b10,
        OFS_RSVD   = 2'b11
    } ofs_sel_e;

    // Signed line correction selected by the offset code; reserved acts as +1.
    function automatic logic signed [2:0] ofs_value(input ofs_sel_e sel);
        case (sel)
            OFS_MINUS1: ofs_value = -3'sd1;
            OFS_PLUS2:  ofs_value = 3'sd2;
            default:    ofs_value = 3'sd1;
        endcase
    endfunction

endpackage

// File: rtl/scanpos_geom.sv
module scanpos_geom #(
    parameter int LINE_W = 12
) (
    input  logic                  pix_mode,
    input  logic                  interlace,
    input  logic [LINE_W-1:0]     htotal,
    input  logic [LINE_W-1:0]     vtotal,
    input  logic [LINE_W-1:0]     vblank_start,
    input  logic [LINE_W-1:0]     vblank_end,
    output logic [LINE_W-1:0]     vt_eff,
    output logic [2*LINE_W-1:0]   vbs_u,
    output logic [2*LINE_W-1:0]   vbe_u,
    output logic [2*LINE_W-1:0]   tot_u
);
    localparam int PIX_W = 2 * LINE_W;

    logic [LINE_W:0]   vbs_round;
    logic [LINE_W-1:0] vbs_e;
    logic [LINE_W-1:0] vbe_e;
    logic [LINE_W-1:0] scale;

    always_comb begin
        vbs_round = {1'b0, vblank_start} + {{LINE_W{1'b0}}, 1'b1};
        vbs_e     = interlace ? vbs_round[LINE_W:1] : vblank_start;
        vbe_e     = interlace ? {1'b0, vblank_end[LINE_W-1:1]} : vblank_end;
        vt_eff    = interlace ? {1'b0, vtotal[LINE_W-1:1]} : vtotal;
        scale     = pix_mode ? htotal : {{(LINE_W-1){1'b0}}, 1'b1};
        vbs_u     = PIX_W'(vbs_e)  * PIX_W'(scale);
        vbe_u     = PIX_W'(vbe_e)  * PIX_W'(scale);
        tot_u     = PIX_W'(vt_eff) * PIX_W'(scale);
    end

endmodule

// File: rtl/scanpos_linemap.sv
module scanpos_linemap
    import scanpos_pkg::*;
#(
    parameter int LINE_W = 12
) (
    input  logic [LINE_W-1:0] raw_line,
    input  logic [LINE_W-1:0] log_line,
    input  logic [LINE_W-1:0] vt,
    input  ofs_sel_e          sel,
    output logic [LINE_W-1:0] fwd_line,
    output logic [LINE_W-1:0] inv_line
);
    localparam int SUM_W = LINE_W + 3;

    logic [SUM_W-1:0] vt_nz;
    logic [SUM_W-1:0] base_fwd;
    logic [SUM_W-1:0] base_inv;
    logic [SUM_W-1:0] sum_fwd;
    logic [SUM_W-1:0] sum_inv;
    logic [SUM_W-1:0] mod_fwd;
    logic [SUM_W-1:0] mod_inv;
    logic signed [2:0] k;

    always_comb begin
        k        = ofs_value(sel);
        vt_nz    = (vt == '0) ? SUM_W'(1) : SUM_W'(vt);
        // Two frame heights keep every sum non-negative for any offset.
        base_fwd = SUM_W'(raw_line) + (vt_nz << 1);
        base_inv = SUM_W'(log_line) + (vt_nz << 1);
        sum_fwd  = base_fwd + SUM_W'(k);
        sum_inv  = base_inv - SUM_W'(k);
        mod_fwd  = sum_fwd % vt_nz;
        mod_inv  = sum_inv % vt_nz;
        fwd_line = mod_fwd[LINE_W-1:0];
        inv_line = mod_inv[LINE_W-1:0];
    end

endmodule

// File: rtl/scanpos_split.sv
module scanpos_split #(
    parameter int LINE_W = 12
) (
    input  logic                        pix_mode,
    input  logic signed [2*LINE_W+1:0]  rel,
    input  logic [LINE_W-1:0]           htotal,
    output logic signed [LINE_W+1:0]    vpos,
    output logic signed [LINE_W+1:0]    hpos,
    output logic                        neg
);
    localparam int REL_W = 2 * LINE_W + 2;

    logic signed [REL_W-1:0] ht_s;
    logic signed [REL_W-1:0] quo;
    logic signed [REL_W-1:0] rem;

    always_comb begin
        ht_s = (htotal == '0) ? REL_W'(1) : signed'(REL_W'(htotal));
        quo  = rel / ht_s;
        rem  = rel % ht_s;
        if (pix_mode) begin
            vpos = quo[LINE_W+1:0];
            hpos = rem[LINE_W+1:0];
        end else begin
            vpos = rel[LINE_W+1:0];
            hpos = '0;
        end
        neg = vpos[LINE_W+1];
    end

endmodule

// File: rtl/scanpos_reporter.sv
module scanpos_reporter
    import scanpos_pkg::*;
#(
    parameter int LINE_W = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic                       pix_mode,
    input  logic                       interlace,
    input  logic [1:0]                 ofs_sel,
    input  logic [2*LINE_W-1:0]        raw_count,
    input  logic [LINE_W-1:0]          logical_line,
    input  logic [LINE_W-1:0]          htotal,
    input  logic [LINE_W-1:0]          hsync_start,
    input  logic [LINE_W-1:0]          vtotal,
    input  logic [LINE_W-1:0]          vblank_start,
    input  logic [LINE_W-1:0]          vblank_end,
    output logic                       out_valid,
    output logic signed [LINE_W+1:0]   vpos,
    output logic signed [LINE_W+1:0]   hpos,
    output logic                       in_vblank,
    output logic [LINE_W-1:0]          hw_line
);
    localparam int PIX_W = 2 * LINE_W;
    localparam int REL_W = PIX_W + 2;
    localparam int POS_W = LINE_W + 2;

    typedef struct packed {
        logic              valid;
        logic              pix;
        logic [PIX_W-1:0]  pos;
        logic [PIX_W-1:0]  shift;
        logic [PIX_W-1:0]  vbs;
        logic [PIX_W-1:0]  vbe;
        logic [PIX_W-1:0]  tot;
        logic [LINE_W-1:0] ht;
        logic [LINE_W-1:0] vt;
        logic [LINE_W-1:0] hw;
    } s1_t;

    typedef struct packed {
        logic                    valid;
        logic                    pix;
        logic signed [REL_W-1:0] rel;
        logic [LINE_W-1:0]       ht;
        logic [LINE_W-1:0]       vt;
        logic [LINE_W-1:0]       hw;
    } s2_t;

    typedef struct packed {
        logic                    valid;
        logic                    pix;
        logic signed [POS_W-1:0] vpos;
        logic signed [POS_W-1:0] hpos;
        logic                    vbl;
        logic [LINE_W-1:0]       ht;
        logic [LINE_W-1:0]       vt;
        logic [LINE_W-1:0]       hw;
    } s3_t;

    typedef struct packed {
        s1_t s1;
        s2_t s2;
        s3_t s3;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    // Stage 1 helpers: timing normalisation and line remapping.
    logic [LINE_W-1:0] vt_eff;
    logic [PIX_W-1:0]  vbs_u, vbe_u, tot_u;
    logic [LINE_W-1:0] fwd_line, inv_line;

    scanpos_geom #(.LINE_W(LINE_W)) u_geom (
        .pix_mode     (pix_mode),
        .interlace    (interlace),
        .htotal       (htotal),
        .vtotal       (vtotal),
        .vblank_start (vblank_start),
        .vblank_end   (vblank_end),
        .vt_eff       (vt_eff),
        .vbs_u        (vbs_u),
        .vbe_u        (vbe_u),
        .tot_u        (tot_u)
    );

    scanpos_linemap #(.LINE_W(LINE_W)) u_linemap (
        .raw_line (raw_count[LINE_W-1:0]),
        .log_line (logical_line),
        .vt       (vt_eff),
        .sel      (ofs_sel_e'(ofs_sel)),
        .fwd_line (fwd_line),
        .inv_line (inv_line)
    );

    // Stage 3 helper: split into line and pixel parts.
    logic signed [POS_W-1:0] split_v, split_h;
    logic                    split_neg;

    scanpos_split #(.LINE_W(LINE_W)) u_split (
        .pix_mode (pipe_q.s2.pix),
        .rel      (pipe_q.s2.rel),
        .htotal   (pipe_q.s2.ht),
        .vpos     (split_v),
        .hpos     (split_h),
        .neg      (split_neg)
    );

    logic [LINE_W-1:0] ht_gap;
    logic [REL_W-1:0]  sum2, wrap2, rel2;

    always_comb begin
        pipe_d = pipe_q;

        // Stage 1: clamp pixel count or correct line, capture thresholds.
        ht_gap = htotal - hsync_start;
        pipe_d.s1.valid = in_valid;
        pipe_d.s1.pix   = pix_mode;
        if (pix_mode) begin
            if (tot_u == '0)
                pipe_d.s1.pos = '0;
            else if (raw_count >= tot_u)
                pipe_d.s1.pos = tot_u - PIX_W'(1);
            else
                pipe_d.s1.pos = raw_count;
            pipe_d.s1.shift = PIX_W'(ht_gap);
        end else begin
            pipe_d.s1.pos   = PIX_W'(fwd_line);
            pipe_d.s1.shift = '0;
        end
        pipe_d.s1.vbs = vbs_u;
        pipe_d.s1.vbe = vbe_u;
        pipe_d.s1.tot = tot_u;
        pipe_d.s1.ht  = htotal;
        pipe_d.s1.vt  = vt_eff;
        pipe_d.s1.hw  = inv_line;

        // Stage 2: sync-aligned shift, wrap, signed relative position.
        sum2  = REL_W'(pipe_q.s1.pos) + REL_W'(pipe_q.s1.shift);
        wrap2 = (sum2 >= REL_W'(pipe_q.s1.tot)) ? sum2 - REL_W'(pipe_q.s1.tot) : sum2;
        if (wrap2 >= REL_W'(pipe_q.s1.vbs))
            rel2 = wrap2 - REL_W'(pipe_q.s1.vbe);
        else
            rel2 = wrap2 + REL_W'(pipe_q.s1.tot) - REL_W'(pipe_q.s1.vbe);
        pipe_d.s2.valid = pipe_q.s1.valid;
        pipe_d.s2.pix   = pipe_q.s1.pix;
        pipe_d.s2.rel   = signed'(rel2);
        pipe_d.s2.ht    = pipe_q.s1.ht;
        pipe_d.s2.vt    = pipe_q.s1.vt;
        pipe_d.s2.hw    = pipe_q.s1.hw;

        // Stage 3: vertical / horizontal split.
        pipe_d.s3.valid = pipe_q.s2.valid;
        pipe_d.s3.pix   = pipe_q.s2.pix;
        pipe_d.s3.vpos  = split_v;
        pipe_d.s3.hpos  = split_h;
        pipe_d.s3.vbl   = split_neg;
        pipe_d.s3.ht    = pipe_q.s2.ht;
        pipe_d.s3.vt    = pipe_q.s2.vt;
        pipe_d.s3.hw    = pipe_q.s2.hw;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign out_valid = pipe_q.s3.valid;
    assign vpos      = pipe_q.s3.vpos;
    assign hpos      = pipe_q.s3.hpos;
    assign in_vblank = pipe_q.s3.vbl;
    assign hw_line   = pipe_q.s3.hw;

    // R10: every accepted sample emerges three edges later.
    p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##3 out_valid);

    // R10: no result without a matching input.
    p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##3 !out_valid);

    // R4: the clamped pixel count stays inside the frame.
    p_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_q.s1.valid && pipe_q.s1.pix && pipe_q.s1.tot != '0)
            |-> (pipe_q.s1.pos < pipe_q.s1.tot));

    // R7: line mode carries no horizontal component.
    p_line_hpos_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !pipe_q.s3.pix) |-> (hpos == '0));

    // R8: the pixel remainder is shorter than one line.
    p_hpos_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && pipe_q.s3.pix)
            |-> ((hpos < 0 ? -hpos : hpos) < signed'(POS_W'(pipe_q.s3.ht))));

    // R2: the inverse line lies inside the frame.
    p_hw_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && pipe_q.s3.vt != '0) |-> (hw_line < pipe_q.s3.vt));

endmodule

// File: tb/scanpos_reporter_test.sv
`timescale 1ns/1ps
module scanpos_reporter_test;
    localparam int LINE_W = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic pix_mode = 1'b0;
    logic interlace = 1'b0;
    logic [1:0] ofs_sel = 2'b01;
    logic [2*LINE_W-1:0] raw_count = '0;
    logic [LINE_W-1:0] logical_line = '0;
    logic [LINE_W-1:0] htotal = 12'd100;
    logic [LINE_W-1:0] hsync_start = 12'd80;
    logic [LINE_W-1:0] vtotal = 12'd20;
    logic [LINE_W-1:0] vblank_start = 12'd16;
    logic [LINE_W-1:0] vblank_end = 12'd20;
    logic out_valid;
    logic signed [LINE_W+1:0] vpos, hpos;
    logic in_vblank;
    logic [LINE_W-1:0] hw_line;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    scanpos_reporter #(.LINE_W(LINE_W)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pix_mode(pix_mode),
        .interlace(interlace), .ofs_sel(ofs_sel), .raw_count(raw_count),
        .logical_line(logical_line), .htotal(htotal), .hsync_start(hsync_start),
        .vtotal(vtotal), .vblank_start(vblank_start), .vblank_end(vblank_end),
        .out_valid(out_valid), .vpos(vpos), .hpos(hpos), .in_vblank(in_vblank),
        .hw_line(hw_line)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected values derived from the requirements.
    task automatic model(input int raw, input int pix, input int ofs, input int inter,
                         input int inv, output int ev, output int eh, output int ehw);
        int vt, vbs, vbe, ht, hs, k, p, tot, rel;
        ht  = int'(htotal);
        hs  = int'(hsync_start);
        vt  = inter ? int'(vtotal) / 2 : int'(vtotal);
        vbs = inter ? (int'(vblank_start) + 1) / 2 : int'(vblank_start);
        vbe = inter ? int'(vblank_end) / 2 : int'(vblank_end);
        k   = (ofs == 0) ? -1 : (ofs == 2) ? 2 : 1;
        ehw = (inv + vt - k) % vt;
        if (pix != 0) begin
            tot = vt * ht;
            p = (raw > tot - 1) ? tot - 1 : raw;
            p = (p + ht - hs) % tot;
            rel = (p >= vbs * ht) ? p - vbe * ht : p + tot - vbe * ht;
            ev = rel / ht;
            eh = rel - ev * ht;
        end else begin
            p = (raw + vt + k) % vt;
            rel = (p >= vbs) ? p - vbe : p + vt - vbe;
            ev = rel;
            eh = 0;
        end
    endtask

    task automatic run_case(input string req, input int raw, input int pix, input int ofs,
                            input int inter, input int inv);
        int ev, eh, ehw;
        model(raw, pix, ofs, inter, inv, ev, eh, ehw);
        @(negedge clk);
        raw_count    = (2*LINE_W)'(raw);
        pix_mode     = pix[0];
        ofs_sel      = ofs[1:0];
        interlace    = inter[0];
        logical_line = LINE_W'(inv);
        in_valid     = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check("R10", "out_valid early", int'(out_valid), 0);
        @(negedge clk);
        check("R10", "out_valid", int'(out_valid), 1);
        check(req, "vpos", int'(vpos), ev);
        check(req, "hpos", int'(hpos), eh);
        check("R9", "in_vblank", int'(in_vblank), (ev < 0) ? 1 : 0);
        check("R2", "hw_line", int'(hw_line), ehw);
    endtask

    task automatic t_reset;
        check("R11", "out_valid", int'(out_valid), 0);
        check("R11", "vpos", int'(vpos), 0);
        check("R11", "hpos", int'(hpos), 0);
        check("R11", "in_vblank", int'(in_vblank), 0);
        check("R11", "hw_line", int'(hw_line), 0);
    endtask

    task automatic t_line_offsets;
        for (int s = 0; s < 4; s++) run_case("R1", 5, 0, s, 0, 3);
        run_case("R7", 9, 0, 1, 0, 0);
    endtask

    task automatic t_line_wrap;
        run_case("R1", 0, 0, 0, 0, 0);
        run_case("R1", 19, 0, 1, 0, 19);
        run_case("R1", 18, 0, 2, 0, 1);
    endtask

    task automatic t_blank_edge;
        run_case("R6", 14, 0, 1, 0, 0);
        run_case("R6", 15, 0, 1, 0, 0);
    endtask

    task automatic t_pixel;
        run_case("R8", 1234, 1, 1, 0, 0);
        run_case("R8", 1590, 1, 1, 0, 0);
        run_case("R5", 1985, 1, 1, 0, 0);
        run_case("R9", 1950, 1, 1, 0, 0);
        run_case("R6", 1685, 1, 2, 0, 7);
    endtask

    task automatic t_clamp;
        run_case("R4", 5000, 1, 1, 0, 0);
        run_case("R4", 1999, 1, 1, 0, 0);
    endtask

    task automatic t_interlace;
        vtotal = 12'd41; vblank_start = 12'd31; vblank_end = 12'd41;
        run_case("R3", 14, 0, 1, 1, 0);
        run_case("R3", 15, 0, 1, 1, 5);
        run_case("R3", 1590, 1, 1, 1, 0);
        vtotal = 12'd20; vblank_start = 12'd16; vblank_end = 12'd20;
    endtask

    task automatic t_inverse;
        run_case("R2", 0, 0, 1, 0, 0);
        run_case("R2", 0, 0, 0, 0, 0);
        run_case("R2", 0, 0, 2, 0, 19);
        run_case("R2", 0, 0, 2, 0, 1);
    endtask

    task automatic t_back_to_back;
        int ev0, eh0, hw0, ev1, eh1, hw1;
        model(3, 0, 1, 0, 2, ev0, eh0, hw0);
        model(700, 1, 1, 0, 4, ev1, eh1, hw1);
        @(negedge clk);
        raw_count = 24'd3; pix_mode = 1'b0; ofs_sel = 2'b01; interlace = 1'b0;
        logical_line = 12'd2; in_valid = 1'b1;
        @(negedge clk);
        raw_count = 24'd700; pix_mode = 1'b1; logical_line = 12'd4;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check("R10", "b2b first valid", int'(out_valid), 1);
        check("R10", "b2b first vpos", int'(vpos), ev0);
        check("R10", "b2b first hw", int'(hw_line), hw0);
        @(negedge clk);
        check("R10", "b2b second valid", int'(out_valid), 1);
        check("R10", "b2b second vpos", int'(vpos), ev1);
        check("R10", "b2b second hpos", int'(hpos), eh1);
        @(negedge clk);
        check("R10", "b2b idle", int'(out_valid), 0);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_line_offsets();
        t_line_wrap();
        t_blank_edge();
        t_pixel();
        t_clamp();
        t_interlace();
        t_inverse();
        t_back_to_back();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

endmodule